// File: doc/BRIEF.md
# Down-Counting Compare-Match Interval Timer

This block is a 32-bit interval timer on a small register port. A down-counter advances on a timer-clock strobe and passes through a 12-bit prescaler on the way. When the counter steps onto the value held in a compare register, the block latches a sticky event flag. It can then raise an interrupt and act on one output pin. There are two counting styles. In the first, the counter wraps from zero to all-ones. In the second, it restarts from a programmable load value, which gives periodic events.

Software sets the prescaler, the counting style, the interrupt enable, the pin action and a clock gate in one control word, and starts the timer with a run bit. A start-mode bit decides what a start does. With the bit set, a start preloads the counter. With it clear, a start resumes from the held count. A self-clearing soft-reset bit returns every register to its reset value and then frees itself.

Top module: `ptmr_top`

## Requirements
- R1: After reset, control reads 0x00000000, status 0, load 0xFFFFFFFF, compare 0 and the counter 0xFFFFFFFF. The interrupt and pin outputs are low.
- R2: Registers sit at byte offsets control 0x00, status 0x04, load 0x08, compare 0x0C and counter 0x10. A read returns data on `rdata_o` one clock after `rd_en_i` is sampled.
- R3: The counter moves only while control bit 0 (run) is 1. It drops by one on every (P+1)-th clock edge where `tick_i` is 1, where P is control bits 15:4.
- R4: While control bits 25:24 (clock gate) are 0, the counter holds whatever the ticks do. Any nonzero value lets it count.
- R5: With control bit 3 (reload) set, a step from 0 loads the counter from the load register.
- R6: With control bit 3 clear, a step from 0 gives 0xFFFFFFFF.
- R7: If control bit 1 (start mode) is 1, a control write that takes run from 0 to 1 loads the counter. It loads the load value if the written reload bit is 1, and 0xFFFFFFFF otherwise. With start mode 0, or with run already 1, the count is kept.
- R8: Status bit 0 sets on the edge where a step makes the counter equal to the compare value. It stays set, and only a status write with bit 0 = 1 clears it; writing 0 leaves it.
- R9: `irq_o` is high exactly while the status flag and control bit 2 (interrupt enable) are both 1.
- R10: On each compare match, control bits 23:22 act on `pin_o`: 0 no change, 1 invert, 2 drive low, 3 drive high.
- R11: Writing control bit 16 = 1 starts a soft reset. Bit 16 reads 1 for SRST_CYCLES clocks while every register returns to its R1 value, and then it clears. Writes made in that window are ignored.
- R12: Writes to the counter offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timer-clock strobe, one per timer tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Compare interrupt |
| pin_o | output | 1 | Compare-driven output pin |

## Verification
A write takes effect on the clock edge that samples it. A counter step, the status flag and the pin all change on the same edge as the tick that causes them, so `irq_o` and `pin_o` are valid at the next falling edge. A read returns data one edge after the strobe. The bench therefore drives every strobe at a falling edge and samples one falling edge later. Between reads it holds `tick_i` low, so each counter value it compares is an exact number of ticks. Soft reset is observed in the middle of its window by a read placed two edges after the request, together with a write placed four edges after it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int DW      = 32;
  localparam int PRESC_W = 12;
  localparam int AW      = 5;

  localparam logic [AW-1:0] OFS_CTRL = 5'h00;
  localparam logic [AW-1:0] OFS_STAT = 5'h04;
  localparam logic [AW-1:0] OFS_LOAD = 5'h08;
  localparam logic [AW-1:0] OFS_CMP  = 5'h0C;
  localparam logic [AW-1:0] OFS_CNT  = 5'h10;

  localparam int B_RUN    = 0;
  localparam int B_SMODE  = 1;
  localparam int B_IEN    = 2;
  localparam int B_RLD    = 3;
  localparam int B_PRE_LO = 4;
  localparam int B_SWR    = 16;
  localparam int B_PIN_LO = 22;
  localparam int B_CS_LO  = 24;

  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  typedef enum logic [1:0] {
    PIN_NONE   = 2'd0,
    PIN_INVERT = 2'd1,
    PIN_LOW    = 2'd2,
    PIN_HIGH   = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic [1:0]         clk_gate;
    pin_act_e           pin_act;
    logic [PRESC_W-1:0] presc;
    logic               rld;
    logic               irq_en;
    logic               start_mode;
    logic               run;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
    ctrl_t c;
    c.run        = w[B_RUN];
    c.start_mode = w[B_SMODE];
    c.irq_en     = w[B_IEN];
    c.rld        = w[B_RLD];
    c.presc      = w[B_PRE_LO +: PRESC_W];
    c.pin_act    = pin_act_e'(w[B_PIN_LO +: 2]);
    c.clk_gate   = w[B_CS_LO +: 2];
    return c;
  endfunction

  function automatic logic [DW-1:0] word_from_ctrl(input ctrl_t c, input logic busy);
    logic [DW-1:0] w;
    w = '0;
    w[B_RUN]                = c.run;
    w[B_SMODE]              = c.start_mode;
    w[B_IEN]                = c.irq_en;
    w[B_RLD]                = c.rld;
    w[B_PRE_LO +: PRESC_W]  = c.presc;
    w[B_SWR]                = busy;
    w[B_PIN_LO +: 2]        = c.pin_act;
    w[B_CS_LO +: 2]         = c.clk_gate;
    return w;
  endfunction
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int SRST_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt_i,
  input  logic          match_i,
  output logic [DW-1:0] rdata_o,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cmp_o,
  output logic          flag_o,
  output logic          busy_o,
  output logic          start_o,
  output logic          start_rld_o
);
  localparam int SW = $clog2(SRST_CYCLES + 1);

  logic [SW-1:0] srst_cnt;
  ctrl_t         ctrl_q;
  logic [DW-1:0] load_q;
  logic [DW-1:0] cmp_q;
  logic          flag_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_mux;
  logic          wr_ok;
  logic          wr_ctrl;
  logic          swr_req;
  logic          ctrl_upd;
  logic          flag_clr;

  assign busy_o   = (srst_cnt != '0);
  assign wr_ok    = wr_en && !busy_o;
  assign wr_ctrl  = wr_ok && (addr == OFS_CTRL);
  assign swr_req  = wr_ctrl && wdata[B_SWR];
  assign ctrl_upd = wr_ctrl && !wdata[B_SWR];
  assign flag_clr = wr_ok && (addr == OFS_STAT) && wdata[0];

  assign start_o     = ctrl_upd && wdata[B_RUN] && wdata[B_SMODE] && !ctrl_q.run;
  assign start_rld_o = wdata[B_RLD];

  always_comb begin
    case (addr)
      OFS_CTRL: rd_mux = word_from_ctrl(ctrl_q, busy_o);
      OFS_STAT: rd_mux = {{(DW-1){1'b0}}, flag_q};
      OFS_LOAD: rd_mux = load_q;
      OFS_CMP:  rd_mux = cmp_q;
      OFS_CNT:  rd_mux = cnt_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_cnt <= '0;
      ctrl_q   <= '0;
      load_q   <= ALL_ONES;
      cmp_q    <= '0;
      flag_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (swr_req) begin
        srst_cnt <= SW'(SRST_CYCLES);
      end else if (busy_o) begin
        srst_cnt <= srst_cnt - 1'b1;
      end

      if (busy_o) begin
        ctrl_q <= '0;
        load_q <= ALL_ONES;
        cmp_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (ctrl_upd) begin
          ctrl_q <= ctrl_from_word(wdata);
        end
        if (wr_ok && (addr == OFS_LOAD)) begin
          load_q <= wdata;
        end
        if (wr_ok && (addr == OFS_CMP)) begin
          cmp_q <= wdata;
        end
        if (match_i) begin
          flag_q <= 1'b1;
        end else if (flag_clr) begin
          flag_q <= 1'b0;
        end
      end

      if (rd_en) begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;
  assign cmp_o   = cmp_q;
  assign flag_o  = flag_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               clear_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               step_o
);
  logic [PRESC_W-1:0] div_q;
  logic               live;

  assign live   = tick_i && run_i && !clear_i;
  assign step_o = live && (div_q >= presc_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      div_q <= '0;
    end else if (live) begin
      if (div_q >= presc_i) begin
        div_q <= '0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
  import ptmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic          start_i,
  input  logic          start_rld_i,
  input  logic          step_i,
  input  logic          rld_i,
  input  logic [DW-1:0] load_i,
  input  logic [DW-1:0] cmp_i,
  output logic [DW-1:0] cnt_o,
  output logic          match_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] step_val;
  logic          advance;

  always_comb begin
    if (cnt_q == '0) begin
      step_val = rld_i ? load_i : ALL_ONES;
    end else begin
      step_val = cnt_q - 1'b1;
    end
  end

  assign advance = step_i && !busy_i && !start_i;
  assign match_o = advance && (step_val == cmp_i);

  always_ff @(posedge clk) begin
    if (rst || busy_i) begin
      cnt_q <= ALL_ONES;
    end else if (start_i) begin
      cnt_q <= start_rld_i ? load_i : ALL_ONES;
    end else if (advance) begin
      cnt_q <= step_val;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ptmr_pin.sv
module ptmr_pin
  import ptmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     busy_i,
  input  logic     match_i,
  input  pin_act_e act_i,
  output logic     pin_o
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst || busy_i) begin
      pin_q <= 1'b0;
    end else if (match_i) begin
      case (act_i)
        PIN_INVERT: pin_q <= !pin_q;
        PIN_LOW:    pin_q <= 1'b0;
        PIN_HIGH:   pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int SRST_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          pin_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] load_v;
  logic [DW-1:0] cmp_v;
  logic [DW-1:0] cnt_v;
  logic          flag_v;
  logic          busy_v;
  logic          start_v;
  logic          start_rld_v;
  logic          step_v;
  logic          match_v;
  logic          run_v;

  assign run_v = ctrl.run && (ctrl.clk_gate != 2'd0);

  ptmr_regs #(.SRST_CYCLES(SRST_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
    .wdata(wdata_i), .cnt_i(cnt_v), .match_i(match_v), .rdata_o(rdata_o),
    .ctrl_o(ctrl), .load_o(load_v), .cmp_o(cmp_v), .flag_o(flag_v),
    .busy_o(busy_v), .start_o(start_v), .start_rld_o(start_rld_v)
  );

  ptmr_prescale u_pre (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_v),
    .clear_i(busy_v || start_v), .presc_i(ctrl.presc), .step_o(step_v)
  );

  ptmr_count u_cnt (
    .clk(clk), .rst(rst), .busy_i(busy_v), .start_i(start_v),
    .start_rld_i(start_rld_v), .step_i(step_v), .rld_i(ctrl.rld),
    .load_i(load_v), .cmp_i(cmp_v), .cnt_o(cnt_v), .match_o(match_v)
  );

  ptmr_pin u_pin (
    .clk(clk), .rst(rst), .busy_i(busy_v), .match_i(match_v),
    .act_i(ctrl.pin_act), .pin_o(pin_o)
  );

  assign irq_o = flag_v && ctrl.irq_en;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int SRST_CYCLES = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          wbit0,
  input logic          irq,
  input logic          pin,
  input logic [DW-1:0] cnt,
  input logic          flag,
  input logic          run,
  input logic          busy,
  input logic          match,
  input logic [1:0]    pin_act
);
  localparam int BW = $clog2(SRST_CYCLES + 2);
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      busy_run <= '0;
    end else if (busy_run <= BW'(SRST_CYCLES)) begin
      busy_run <= busy_run + 1'b1;
    end
  end

  // R3: outside control writes and soft reset, a nonzero count either holds or drops by one
  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && addr == OFS_CTRL) && !busy && cnt != '0)
    |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  // R3: a stopped counter with no control write stays put
  p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && addr == OFS_CTRL) && !busy) |=> $stable(cnt));

  // R8: the flag is sticky unless a clearing write or soft reset occurs
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !busy && !(wr_en && addr == OFS_STAT && wbit0)) |=> flag);

  // R9: a clearing write with no new match drops the interrupt
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && wr_en && addr == OFS_STAT && wbit0 && !busy && !match) |=> !irq);

  // R10: with no pin action selected the pin keeps its level
  p_pin_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (pin_act == 2'd0 && !busy) |=> $stable(pin));

  // R11: the soft reset window never outlasts its length
  p_srst_window_r11: assert property (@(posedge clk) disable iff (rst)
    busy_run <= BW'(SRST_CYCLES));
endmodule

bind ptmr_top ptmr_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i), .wbit0(wdata_i[0]),
  .irq(irq_o), .pin(pin_o), .cnt(cnt_v), .flag(flag_v), .run(ctrl.run),
  .busy(busy_v), .match(match_v), .pin_act(ctrl.pin_act)
);

// File: tb/tb_ptmr_top.sv
`timescale 1ns/1ps
module tb_ptmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic        pin_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10;
  localparam logic [31:0] C_RUN = 32'h1, C_SMODE = 32'h2, C_IEN = 32'h4,
                          C_RLD = 32'h8, C_SWR = 32'h0001_0000, C_GATE = 32'h0100_0000;

  ptmr_top #(.SRST_CYCLES(8)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic soft_reset();
    logic [31:0] d;
    wr(A_CTRL, C_SWR);
    repeat (12) @(negedge clk);
    rd(A_CTRL, d);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); check("R1 status", d, 32'h0);
    rd(A_LOAD, d); check("R1 load", d, 32'hFFFF_FFFF);
    rd(A_CMP, d);  check("R1 compare", d, 32'h0);
    rd(A_CNT, d);  check("R1 counter", d, 32'hFFFF_FFFF);
    check("R1 irq", irq_o, 0);
    check("R1 pin", pin_o, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(A_CMP, 32'hA5A5_0001);
    rd(A_CMP, d); check("R2 compare readback", d, 32'hA5A5_0001);
    wr(A_CTRL, C_GATE | (32'd3 << 22) | (32'hABC << 4) | C_IEN);
    rd(A_CTRL, d); check("R2 ctrl readback", d, C_GATE | (32'd3 << 22) | (32'hABC << 4) | C_IEN);
    rd(5'h14, d); check("R2 unmapped", d, 32'h0);
    soft_reset();
  endtask

  task automatic t_start_and_count();
    logic [31:0] d;
    wr(A_LOAD, 32'h40);
    wr(A_CTRL, C_GATE | C_RLD | C_SMODE | C_RUN);
    rd(A_CNT, d); check("R7 start loads load value", d, 32'h40);
    ticks(5);
    rd(A_CNT, d); check("R3 five steps", d, 32'h3B);
    wr(A_CTRL, C_GATE | C_RLD | C_SMODE | C_RUN);
    rd(A_CNT, d); check("R7 no reload while running", d, 32'h3B);
    wr(A_CTRL, C_GATE | C_RLD);
    ticks(3);
    rd(A_CNT, d); check("R3 stopped holds", d, 32'h3B);
    wr(A_CTRL, C_GATE | C_RLD | C_RUN);
    rd(A_CNT, d); check("R7 resume keeps count", d, 32'h3B);
    ticks(1);
    rd(A_CNT, d); check("R3 step after resume", d, 32'h3A);
    soft_reset();
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(A_CTRL, C_GATE | (32'd3 << 4) | C_SMODE | C_RUN);
    ticks(3);
    rd(A_CNT, d); check("R3 prescale 3 ticks", d, 32'hFFFF_FFFF);
    ticks(1);
    rd(A_CNT, d); check("R3 prescale 4th tick", d, 32'hFFFF_FFFE);
    ticks(4);
    rd(A_CNT, d); check("R3 prescale 8 ticks", d, 32'hFFFF_FFFD);
    soft_reset();
  endtask

  task automatic t_gate_off();
    logic [31:0] d;
    wr(A_LOAD, 32'h20);
    wr(A_CTRL, C_RLD | C_SMODE | C_RUN);
    ticks(5);
    rd(A_CNT, d); check("R4 clock gate off", d, 32'h20);
    soft_reset();
  endtask

  task automatic t_reload_and_wrap();
    logic [31:0] d;
    wr(A_LOAD, 32'h3);
    wr(A_CTRL, C_GATE | C_RLD | C_SMODE | C_RUN);
    ticks(4);
    rd(A_CNT, d); check("R5 reload from zero", d, 32'h3);
    ticks(3);
    wr(A_CTRL, C_GATE);
    rd(A_CNT, d); check("R5 reached zero", d, 32'h0);
    wr(A_CTRL, C_GATE | C_RUN);
    ticks(1);
    rd(A_CNT, d); check("R6 free-run wrap", d, 32'hFFFF_FFFF);
    soft_reset();
  endtask

  task automatic t_flag_irq();
    logic [31:0] d;
    wr(A_LOAD, 32'h5);
    wr(A_CMP, 32'h3);
    wr(A_CTRL, C_GATE | C_IEN | C_RLD | C_SMODE | C_RUN);
    ticks(1);
    check("R9 irq before match", irq_o, 0);
    ticks(1);
    check("R9 irq on match", irq_o, 1);
    rd(A_STAT, d); check("R8 flag set", d, 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R8 write 0 keeps flag", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); check("R8 write 1 clears", d, 32'h0);
    check("R9 irq cleared", irq_o, 0);
    ticks(6);
    check("R8 periodic rematch", irq_o, 1);
    wr(A_CTRL, C_GATE | C_RLD | C_RUN);
    check("R9 irq masked", irq_o, 0);
    rd(A_STAT, d); check("R9 flag kept when masked", d, 32'h1);
    soft_reset();
  endtask

  task automatic t_pin();
    wr(A_LOAD, 32'h2);
    wr(A_CMP, 32'h1);
    wr(A_CTRL, C_GATE | (32'd1 << 22) | C_RLD | C_SMODE | C_RUN);
    ticks(1); check("R10 invert to 1", pin_o, 1);
    ticks(3); check("R10 invert to 0", pin_o, 0);
    wr(A_CTRL, C_GATE | (32'd3 << 22) | C_RLD | C_RUN);
    ticks(3); check("R10 drive high", pin_o, 1);
    wr(A_CTRL, C_GATE | C_RLD | C_RUN);
    ticks(3); check("R10 no action holds", pin_o, 1);
    wr(A_CTRL, C_GATE | (32'd2 << 22) | C_RLD | C_RUN);
    ticks(3); check("R10 drive low", pin_o, 0);
    wr(A_CTRL, C_GATE | (32'd3 << 22) | C_RLD | C_RUN);
    ticks(3); check("R10 high again", pin_o, 1);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(A_CMP, 32'h1);
    wr(A_CTRL, C_GATE | C_IEN | C_RLD | C_RUN);
    ticks(3);
    check("R11 irq before reset", irq_o, 1);
    wr(A_CTRL, C_SWR);
    rd(A_CTRL, d); check("R11 busy bit reads 1", d & C_SWR, C_SWR);
    wr(A_LOAD, 32'h1234);
    repeat (10) @(negedge clk);
    rd(A_CTRL, d); check("R11 ctrl self-cleared", d, 32'h0);
    rd(A_LOAD, d); check("R11 write in window ignored", d, 32'hFFFF_FFFF);
    rd(A_CMP, d);  check("R11 compare reset", d, 32'h0);
    rd(A_STAT, d); check("R11 flag reset", d, 32'h0);
    rd(A_CNT, d);  check("R11 counter reset", d, 32'hFFFF_FFFF);
    check("R11 pin reset", pin_o, 0);
    check("R11 irq reset", irq_o, 0);
  endtask

  task automatic t_cnt_readonly();
    logic [31:0] d;
    wr(A_CNT, 32'h1234);
    rd(A_CNT, d); check("R12 counter write ignored", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_regmap();
    t_start_and_count();
    t_prescale();
    t_gate_off();
    t_reload_and_wrap();
    t_flag_irq();
    t_pin();
    t_soft_reset();
    t_cnt_readonly();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule